// File: doc/BRIEF.md
# Edge-Triggered Interrupt Pending Controller

This block gathers level status flags from a peripheral (receive error, transmit error and similar conditions) into latched pending bits. One pending bit per channel is set only when that channel's flag goes from low to high while the channel's enable bit is set. A flag that is already high, or one that rises while its channel is disabled, latches nothing until the flag falls and rises again. Flags keep tracking their source whether the channel is enabled or not.

A mask bit for each channel decides whether a set pending bit drives the single interrupt request. Masking never stops latching. Software can mask a channel and then read the pending bits after a block transfer to find out whether any error happened during it. Software clears pending bits by writing zeros to them. Clearing a channel's enable bit also clears its pending bit.

Each channel runs a two-state tracker for its flag. In `FLAG_LOW` the last sampled flag was 0. A sampled 1 takes the transition `rise`, which moves it to `FLAG_HIGH` and reports an edge. In `FLAG_HIGH` a sampled 0 takes the transition `fall` back to `FLAG_LOW`. Any other sample keeps the state. Reset puts every tracker in `FLAG_LOW`.

Top module: `irq_pend_ctrl`

## Requirements
- R1: After reset, the enable, mask and pending outputs are all zero and `irq` is low.
- R2: If a channel's flag is 1 while its previous sample was 0 and its enable bit is 1, the channel's pending bit reads 1 after the next clock edge. A flag held at 1 never sets the pending bit again after it has been cleared.
- R3: An edge that arrives while the channel is disabled is lost. Setting the enable bit later while the flag is still 1 leaves pending at 0. Only a later fall and rise of the flag sets the pending bit.
- R4: A pending bit latches whatever its mask bit is. With the mask bit at 0, the channel does not drive `irq`.
- R5: A pending bit stays at 1 until software clears it. A write with `wr_sel`=2'b10 clears every pending bit whose `wr_data` bit is 0. Bits written as 1 leave the pending state unchanged.
- R6: `irq` is 1 exactly when at least one channel has both its pending bit and its mask bit at 1.
- R7: A write with `wr_sel`=2'b00 clears the pending bit of every channel whose new enable bit is 0.
- R8: If a qualifying edge and a software clear of the same pending bit arrive in the same cycle, the pending bit ends up at 1.
- R9: A write loads `wr_data` into the enable bits when `wr_sel`=2'b00 and into the mask bits when `wr_sel`=2'b01. `wr_sel`=2'b11 changes nothing. The new value appears after the clock edge on which `wr_en` is 1.
- R10: Channels are independent. Stimulus on one channel never changes another channel's pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flag | input | N_CH | Level status flags, one per channel |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 00 enable, 01 mask, 10 pending clear, 11 none |
| wr_data | input | N_CH | Write data |
| enable | output | N_CH | Channel enable bits |
| mask | output | N_CH | Channel mask bits |
| pending | output | N_CH | Latched pending bits |
| irq | output | 1 | Combined interrupt request |

## Verification
Suppose a tracker is stuck in the wrong state. It then shows up at the `pending` port one clock edge after the next flag change, as a bit that either latches a level instead of an edge or misses a real edge. A corrupted enable or mask bit shows within one cycle. It appears on the `enable` or `mask` port, and through a wrong `irq` once the affected channel has a pending bit set. Every channel is driven through the same sequence, one channel at a time, while the pending bits of the other channels are checked for leakage. Every mask value, and every pending-clear pattern, is then swept against an arithmetic expectation for `irq`.

// File: rtl/irq_pend_pkg.sv
package irq_pend_pkg;

    typedef enum logic [1:0] {
        SEL_ENABLE  = 2'b00,
        SEL_MASK    = 2'b01,
        SEL_PENDING = 2'b10,
        SEL_NONE    = 2'b11
    } wr_sel_e;

    typedef enum logic {
        FLAG_LOW  = 1'b0,
        FLAG_HIGH = 1'b1
    } flag_state_e;

endpackage

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
    import irq_pend_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [N_CH-1:0] wr_data,
    output logic [N_CH-1:0] en_q,
    output logic [N_CH-1:0] mask_q
);

    logic wr_en_sel;
    logic wr_mask_sel;

    always_comb begin
        wr_en_sel   = wr_en && (wr_sel_e'(wr_sel) == SEL_ENABLE);
        wr_mask_sel = wr_en && (wr_sel_e'(wr_sel) == SEL_MASK);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            mask_q <= '0;
        end else begin
            if (wr_en_sel)   en_q   <= wr_data;
            if (wr_mask_sel) mask_q <= wr_data;
        end
    end

    assert_cfg_load_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask_sel |=> (mask_q == $past(wr_data)));

endmodule

// File: rtl/irq_edge_chan.sv
module irq_edge_chan
    import irq_pend_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic flag_i,
    input  logic en_i,
    input  logic sw_clr_i,
    input  logic dis_clr_i,
    output logic pend_o
);

    flag_state_e state_q;
    flag_state_e state_d;
    logic        rise;
    logic        pend_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FLAG_LOW;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        rise    = 1'b0;
        unique case (state_q)
            FLAG_LOW: begin
                if (flag_i) begin
                    state_d = FLAG_HIGH;
                    rise    = 1'b1;
                end
            end
            FLAG_HIGH: begin
                if (!flag_i) state_d = FLAG_LOW;
            end
            default: state_d = FLAG_LOW;
        endcase
    end

    always_comb begin
        if (dis_clr_i)            pend_d = 1'b0;
        else if (rise && en_i)    pend_d = 1'b1;
        else if (sw_clr_i)        pend_d = 1'b0;
        else                      pend_d = pend_o;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pend_o <= 1'b0;
        else        pend_o <= pend_d;
    end

    assert_set_needs_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_o) |-> ($past(en_i) && $past(flag_i)));

    assert_hold_until_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pend_o) && !$past(sw_clr_i) && !$past(dis_clr_i)) |-> pend_o);

    assert_disable_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dis_clr_i |=> !pend_o);

    assert_edge_beats_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr_i && !dis_clr_i && en_i && flag_i && state_q == FLAG_LOW) |=> pend_o);

endmodule

// File: rtl/irq_any.sv
module irq_any #(
    parameter int N_CH = 8
) (
    input  logic [N_CH-1:0] pend_i,
    input  logic [N_CH-1:0] mask_i,
    output logic            req_o
);

    always_comb begin
        req_o = |(pend_i & mask_i);
    end

endmodule

// File: rtl/irq_pend_ctrl.sv
module irq_pend_ctrl
    import irq_pend_pkg::*;
#(
    parameter int N_CH = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_CH-1:0] flag,
    input  logic            wr_en,
    input  logic [1:0]      wr_sel,
    input  logic [N_CH-1:0] wr_data,
    output logic [N_CH-1:0] enable,
    output logic [N_CH-1:0] mask,
    output logic [N_CH-1:0] pending,
    output logic            irq
);

    logic wr_pend_sel;
    logic wr_en_sel;

    always_comb begin
        wr_pend_sel = wr_en && (wr_sel_e'(wr_sel) == SEL_PENDING);
        wr_en_sel   = wr_en && (wr_sel_e'(wr_sel) == SEL_ENABLE);
    end

    irq_cfg_regs #(.N_CH(N_CH)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .en_q    (enable),
        .mask_q  (mask)
    );

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_chan
        irq_edge_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .flag_i    (flag[ch]),
            .en_i      (enable[ch]),
            .sw_clr_i  (wr_pend_sel && !wr_data[ch]),
            .dis_clr_i (wr_en_sel && !wr_data[ch]),
            .pend_o    (pending[ch])
        );
    end

    irq_any #(.N_CH(N_CH)) u_any (
        .pend_i (pending),
        .mask_i (mask),
        .req_o  (irq)
    );

    assert_irq_has_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($countones(pending) > 0 && $countones(mask) > 0));

    assert_masked_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);

    assert_ones_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pend_sel && wr_data == '1) |=> ((pending & $past(pending)) == $past(pending)));

endmodule

// File: tb/irq_pend_ctrl_tb.sv
module irq_pend_ctrl_tb;

    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] flag = '0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_sel = 2'b11;
    logic [N-1:0] wr_data = '0;
    logic [N-1:0] enable, mask, pending;
    logic         irq;

    int vectors = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irq_pend_ctrl #(.N_CH(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .flag(flag), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .enable(enable), .mask(mask), .pending(pending), .irq(irq)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [N-1:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        tick();
        wr_en = 1'b0; wr_sel = 2'b11;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 enable", 32'(enable), 32'h0);
        chk("R1 mask", 32'(mask), 32'h0);
        chk("R1 pending", 32'(pending), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);

        for (int i = 0; i < N; i++) begin
            logic [N-1:0] b;
            b = N'(1) << i;
            wr(2'b00, b);
            chk("R9 enable load", 32'(enable), 32'(b));
            wr(2'b11, '1);
            chk("R9 none sel", 32'(enable), 32'(b));
            flag = b; tick();
            chk("R2 edge sets", 32'(pending), 32'(b));
            chk("R4 masked no irq", 32'(irq), 32'h0);
            wr(2'b10, ~b);
            chk("R5 clear by zero", 32'(pending), 32'h0);
            tick(); tick();
            chk("R2 level no reset", 32'(pending), 32'h0);
            flag = '0; tick(); flag = b; tick();
            chk("R2 second edge", 32'(pending), 32'(b));
            tick(); tick();
            chk("R5 holds", 32'(pending), 32'(b));
            wr(2'b10, '1);
            chk("R5 ones ignored", 32'(pending), 32'(b));
            wr(2'b10, ~b);
            flag = '0; tick();
            flag = b; wr_en = 1'b1; wr_sel = 2'b10; wr_data = ~b;
            tick();
            wr_en = 1'b0; wr_sel = 2'b11;
            chk("R8 edge wins", 32'(pending), 32'(b));
            wr(2'b01, b);
            chk("R6 irq on", 32'(irq), 32'h1);
            wr(2'b01, '0);
            chk("R6 irq off", 32'(irq), 32'h0);
            wr(2'b00, '0);
            chk("R7 disable clears", 32'(pending), 32'h0);
            flag = '0; tick(); flag = b; tick();
            chk("R3 disabled edge lost", 32'(pending), 32'h0);
            wr(2'b00, b); tick();
            chk("R3 late enable", 32'(pending), 32'h0);
            flag = '0; tick(); flag = b; tick();
            chk("R3 re-edge sets", 32'(pending), 32'(b));
            chk("R10 isolation", 32'(pending & ~b), 32'h0);
            flag = '0; wr(2'b00, '0);
        end

        // R6 mask sweep with all pending set
        wr(2'b00, '1);
        flag = '1; tick();
        chk("R2 all set", 32'(pending), 32'hff);
        for (int m = 0; m < 256; m++) begin
            wr(2'b01, N'(m));
            chk("R6 mask sweep", 32'(irq), 32'(m != 0));
        end
        // R5 clear pattern sweep
        wr(2'b01, 8'h55);
        for (int p = 0; p < 256; p++) begin
            flag = '0; tick(); flag = '1; tick();
            wr(2'b10, N'(p));
            chk("R5 clear pattern", 32'(pending), 32'(p));
            chk("R6 irq pattern", 32'(irq), 32'((p & 8'h55) != 0));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule